// File: doc/BRIEF.md
# Variable-Count Shift Execute Stage

This block is the one-cycle execute stage for a group of 32-bit shift instructions whose count comes from a register. It holds an eight-entry register file and a four-bit flag set (zero, sign, overflow, carry). Each valid cycle it takes an 8-bit addressing byte and the low byte of the count register. From the addressing byte it decodes a shift kind and a destination register. It then shifts that register's current value and, on the next rising clock edge, writes the result back and updates the flags together.

Three shift kinds are supported: logical left, logical right and arithmetic right. The count is masked to five bits, so a count of zero after masking leaves the machine state untouched. An addressing byte that does not name register-direct mode, or that names an undefined shift kind, raises an error strobe and changes nothing. A side load port and a combinational read port let the surrounding pipeline put values into the register file and look at them.

Top module: `shift_exec_unit`

## Requirements
- R1: The addressing byte `modrm` is decoded as follows. Bits 7:6 must be 2'b11 (register-direct). Bits 5:3 pick the shift kind: 4 is logical left, 5 is logical right, 7 is arithmetic right. Bits 2:0 index the destination register (index 3 is the base register). On a valid, legal cycle with a nonzero count, the shifted value is written to that register on the next rising edge.
- R2: The applied count is `count_byte` ANDed with 0x1F. Bits 7:5 of `count_byte` have no effect, so a count byte of 0x21 acts exactly as a count of 1.
- R3: A logical left shift fills vacated low bits with zeros; 13 shifted left by 1 gives 0x1A.
- R4: A logical right shift fills vacated high bits with zeros. By 1, 0xFFFFFFFD gives 0x7FFFFFFE, and both 26 and 27 give 0x0D.
- R5: An arithmetic right shift fills vacated high bits with copies of bit 31. By 1, 0xFFFFFFFD gives 0xFFFFFFFE, and both 26 and 27 give 0x0D.
- R6: After a nonzero shift, `zf` is set exactly when the 32-bit result is zero. `sf` equals result bit 31 for left and arithmetic right shifts, and is cleared for a logical right shift.
- R7: After a nonzero shift, `cf` holds the last bit shifted out. For a left shift this is original bit (32 − count); for either right shift it is original bit (count − 1).
- R8: At a count of exactly 1, `of` is set as follows: bit 31 XOR bit 30 of the original value for a left shift, bit 31 of the original value for a logical right shift, and 0 for an arithmetic right shift. At any count from 2 to 31, `of` keeps its previous value.
- R9: When the masked count is zero, the destination register and all four flags keep their values.
- R10: When `valid` is high and the byte is not register-direct or names a shift kind other than 4, 5 or 7, `err` is high in that same cycle. No register and no flag changes.
- R11: A synchronous reset clears all eight registers and all four flags.
- R12: A high `ld_en` writes `ld_data` into register `ld_idx` on the rising edge, and `rd_data` shows register `rd_idx` combinationally. If an executed shift and a load target the same register on one edge, the shift result is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Execute the shift described this cycle |
| modrm | input | 8 | Addressing byte: mode, shift kind, destination |
| count_byte | input | 8 | Low byte of the count register |
| ld_en | input | 1 | Side load enable |
| ld_idx | input | 3 | Side load register index |
| ld_data | input | 32 | Side load value |
| rd_idx | input | 3 | Read port register index |
| rd_data | output | 32 | Read port value |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| of | output | 1 | Overflow flag |
| cf | output | 1 | Carry flag |
| err | output | 1 | Illegal shift kind or addressing mode strobe |

## Verification
The bound checker watches the flag rules that follow directly from the ports on every cycle. It checks that an illegal byte strobes `err` and never enables a write. It checks that a masked-zero count leaves the flags stable, that a logical right shift clears `sf`, and that an arithmetic right shift by one clears `of`. It also checks that `of` holds at counts above one and that reset clears the flags. Result values, fill bits and the carry bit taken from a count-dependent position can only be shown by the bench's scenarios. These include the required vectors at count 1, values with the top bits set, counts of 31 and with masked high count bits, a load on the same edge as a shift, and a long run of random shifts compared against a bit-at-a-time model.

// File: rtl/shift_exec_pkg.sv
package shift_exec_pkg;

   // Decoded shift kind
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_SHL  = 2'd1,
      OP_SHR  = 2'd2,
      OP_SAR  = 2'd3
   } shop_e;

   // Flag bundle kept by the unit
   typedef struct packed {
      logic zf;
      logic sf;
      logic of;
      logic cf;
   } flags_t;

   // Addressing-byte encodings (fixed by the instruction format)
   localparam logic [1:0] MODE_REG_DIRECT = 2'b11;
   localparam logic [2:0] KIND_SHL        = 3'd4;
   localparam logic [2:0] KIND_SHR        = 3'd5;
   localparam logic [2:0] KIND_SAR        = 3'd7;

endpackage

// File: rtl/shift_decode.sv
module shift_decode
   import shift_exec_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic [7:0]       modrm,
   output shop_e            op,
   output logic             legal,
   output logic [IDX_W-1:0] dst_idx
);

   logic [1:0] mode_f;
   logic [2:0] kind_f;

   assign mode_f  = modrm[7:6];
   assign kind_f  = modrm[5:3];
   assign dst_idx = modrm[IDX_W-1:0];

   always_comb begin
      op = OP_NONE;
      if (mode_f == MODE_REG_DIRECT) begin
         case (kind_f)
            KIND_SHL: op = OP_SHL;
            KIND_SHR: op = OP_SHR;
            KIND_SAR: op = OP_SAR;
            default:  op = OP_NONE;
         endcase
      end
   end

   assign legal = (op != OP_NONE);

endmodule

// File: rtl/shift_core.sv
module shift_core
   import shift_exec_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int CNT_W = $clog2(DATA_W)
) (
   input  shop_e             op,
   input  logic [DATA_W-1:0] operand,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              of_prev,
   output logic [DATA_W-1:0] result,
   output flags_t            flags_out
);

   logic              is_left;
   logic              fill;
   logic [DATA_W-1:0] op_rev;
   logic [DATA_W-1:0] res_rev;
   logic [DATA_W-1:0] stg [0:CNT_W];
   logic [CNT_W-1:0]  idx_left;
   logic [CNT_W-1:0]  idx_right;
   logic              cnt_is_one;

   assign is_left = (op == OP_SHL);
   assign fill    = (op == OP_SAR) & operand[DATA_W-1];

   // Left shifts reuse the right-shift network on bit-reversed data
   for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign op_rev[i]  = operand[DATA_W-1-i];
      assign res_rev[i] = stg[CNT_W][DATA_W-1-i];
   end

   assign stg[0] = is_left ? op_rev : operand;

   // Logarithmic right-shift network, one stage per count bit
   for (genvar s = 0; s < CNT_W; s++) begin : g_stage
      localparam int STEP = 1 << s;
      assign stg[s+1] = cnt[s] ? {{STEP{fill}}, stg[s][DATA_W-1:STEP]} : stg[s];
   end

   assign result = is_left ? res_rev : stg[CNT_W];

   // Last bit out: left takes bit (DATA_W - cnt), modulo wraps in CNT_W bits
   assign idx_left   = '0 - cnt;
   assign idx_right  = cnt - 1'b1;
   assign cnt_is_one = (cnt == CNT_W'(1));

   always_comb begin
      flags_out.zf = (result == '0);
      flags_out.sf = (op == OP_SHR) ? 1'b0 : result[DATA_W-1];
      flags_out.cf = is_left ? operand[idx_left] : operand[idx_right];
      flags_out.of = of_prev;
      if (cnt_is_one) begin
         case (op)
            OP_SHL:  flags_out.of = operand[DATA_W-1] ^ operand[DATA_W-2];
            OP_SHR:  flags_out.of = operand[DATA_W-1];
            default: flags_out.of = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/shift_regfile.sv
module shift_regfile #(
   parameter int DATA_W = 32,
   parameter int NREG   = 8,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              exe_we,
   input  logic [IDX_W-1:0]  exe_idx,
   input  logic [DATA_W-1:0] exe_data,
   input  logic              ld_we,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [IDX_W-1:0]  src_idx,
   output logic [DATA_W-1:0] src_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] regs [NREG];

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            regs[r] <= '0;
         end else if (exe_we && exe_idx == IDX_W'(r)) begin
            regs[r] <= exe_data;
         end else if (ld_we && ld_idx == IDX_W'(r)) begin
            regs[r] <= ld_data;
         end
      end
   end

   assign src_data = regs[src_idx];
   assign rd_data  = regs[rd_idx];

endmodule

// File: rtl/shift_exec_unit.sv
module shift_exec_unit
   import shift_exec_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NREG     = 8,
   parameter int CNT_IN_W = 8,
   localparam int CNT_W   = $clog2(DATA_W),
   localparam int IDX_W   = $clog2(NREG)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                valid,
   input  logic [7:0]          modrm,
   input  logic [CNT_IN_W-1:0] count_byte,
   input  logic                ld_en,
   input  logic [IDX_W-1:0]    ld_idx,
   input  logic [DATA_W-1:0]   ld_data,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [DATA_W-1:0]   rd_data,
   output logic                zf,
   output logic                sf,
   output logic                of,
   output logic                cf,
   output logic                err
);

   localparam logic [CNT_IN_W-1:0] CNT_MASK = CNT_IN_W'((1 << CNT_W) - 1);

   // Elaboration-time parameter checks
   if (NREG != 8) begin : g_bad_nreg
      $error("shift_exec_unit: NREG must be 8 to match the 3-bit register field");
   end
   if ((1 << CNT_W) != DATA_W || DATA_W < 8) begin : g_bad_width
      $error("shift_exec_unit: DATA_W must be a power of two of at least 8");
   end
   if (CNT_IN_W < CNT_W) begin : g_bad_cnt
      $error("shift_exec_unit: CNT_IN_W narrower than the applied count");
   end

   shop_e             op;
   logic              legal;
   logic [IDX_W-1:0]  dst_idx;
   logic [CNT_IN_W-1:0] cnt_masked;
   logic [CNT_W-1:0]  cnt;
   logic              cnt_nz;
   logic              exe_wr;
   logic [DATA_W-1:0] src_val;
   logic [DATA_W-1:0] shifted;
   flags_t            flags_q;
   flags_t            flags_nx;

   shift_decode #(.IDX_W(IDX_W)) u_dec (
      .modrm   (modrm),
      .op      (op),
      .legal   (legal),
      .dst_idx (dst_idx)
   );

   assign cnt_masked = count_byte & CNT_MASK;
   assign cnt        = cnt_masked[CNT_W-1:0];
   assign cnt_nz     = (cnt_masked != '0);
   assign exe_wr     = valid && legal && cnt_nz;
   assign err        = valid && !legal;

   shift_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
      .clk      (clk),
      .rst      (rst),
      .exe_we   (exe_wr),
      .exe_idx  (dst_idx),
      .exe_data (shifted),
      .ld_we    (ld_en),
      .ld_idx   (ld_idx),
      .ld_data  (ld_data),
      .src_idx  (dst_idx),
      .src_data (src_val),
      .rd_idx   (rd_idx),
      .rd_data  (rd_data)
   );

   shift_core #(.DATA_W(DATA_W)) u_core (
      .op        (op),
      .operand   (src_val),
      .cnt       (cnt),
      .of_prev   (flags_q.of),
      .result    (shifted),
      .flags_out (flags_nx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         flags_q <= '0;
      end else if (exe_wr) begin
         flags_q <= flags_nx;
      end
   end

   assign zf = flags_q.zf;
   assign sf = flags_q.sf;
   assign of = flags_q.of;
   assign cf = flags_q.cf;

endmodule

// File: rtl/shift_exec_chk.sv
module shift_exec_chk #(
   parameter int DATA_W   = 32,
   parameter int CNT_IN_W = 8
) (
   input logic                clk,
   input logic                rst,
   input logic                valid,
   input logic [7:0]          modrm,
   input logic [CNT_IN_W-1:0] count_byte,
   input logic                err,
   input logic                zf,
   input logic                sf,
   input logic                of,
   input logic                cf,
   input logic                exe_wr
);

   localparam logic [CNT_IN_W-1:0] MSK = CNT_IN_W'((1 << $clog2(DATA_W)) - 1);

   logic [CNT_IN_W-1:0] eff;
   logic                reg_mode;
   logic                kind_ok;

   assign eff      = count_byte & MSK;
   assign reg_mode = (modrm[7:6] == 2'b11);
   assign kind_ok  = (modrm[5:3] == 3'd4) || (modrm[5:3] == 3'd5) || (modrm[5:3] == 3'd7);

   // R10: illegal byte raises the strobe
   p_bad_byte_err_r10: assert property (@(posedge clk) disable iff (rst)
      (valid && !(reg_mode && kind_ok)) |-> err);

   // R10: the strobe never coincides with a write
   p_err_no_write_r10: assert property (@(posedge clk) disable iff (rst)
      err |-> !exe_wr);

   // R9: masked-zero count keeps every flag
   p_zero_cnt_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (valid && eff == '0) |=> $stable({zf, sf, of, cf}));

   // R6: logical right shift clears sign
   p_shr_sf_low_r6: assert property (@(posedge clk) disable iff (rst)
      (valid && reg_mode && modrm[5:3] == 3'd5 && eff != '0) |=> !sf);

   // R8: arithmetic right by one clears overflow
   p_sar_of_low_r8: assert property (@(posedge clk) disable iff (rst)
      (valid && reg_mode && modrm[5:3] == 3'd7 && eff == CNT_IN_W'(1)) |=> !of);

   // R8: counts above one leave overflow alone
   p_of_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (valid && eff > CNT_IN_W'(1)) |=> $stable(of));

   // R11: reset clears all flags
   p_reset_clear_r11: assert property (@(posedge clk)
      rst |=> !(zf || sf || of || cf));

endmodule

bind shift_exec_unit shift_exec_chk #(.DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .valid      (valid),
   .modrm      (modrm),
   .count_byte (count_byte),
   .err        (err),
   .zf         (zf),
   .sf         (sf),
   .of         (of),
   .cf         (cf),
   .exe_wr     (exe_wr)
);

// File: tb/shift_exec_unit_tb.sv
module shift_exec_unit_tb;

   typedef struct {
      string       tag;
      logic [2:0]  idx;
      logic [31:0] val;
      logic [3:0]  flg;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid = 1'b0;
   logic [7:0]  modrm = '0;
   logic [7:0]  count_byte = '0;
   logic        ld_en = 1'b0;
   logic [2:0]  ld_idx = '0;
   logic [31:0] ld_data = '0;
   logic [2:0]  rd_idx = '0;
   logic [31:0] rd_data;
   logic        zf, sf, of, cf, err;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;
   exp_t sb_q [$];

   logic [31:0] m_reg [8];
   logic        m_zf, m_sf, m_of, m_cf;

   always #5 clk = ~clk;

   shift_exec_unit u_dut (
      .clk(clk), .rst(rst), .valid(valid), .modrm(modrm), .count_byte(count_byte),
      .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data), .rd_idx(rd_idx),
      .rd_data(rd_data), .zf(zf), .sf(sf), .of(of), .cf(cf), .err(err)
   );

   // Reference: one bit position per step
   task automatic model_exec(input logic [7:0] mr, input logic [7:0] cb, output logic bad);
      logic [2:0]  kind;
      int          c;
      logic [31:0] v, orig;
      logic        lastbit;
      kind = mr[5:3];
      c    = int'(cb & 8'h1f);
      bad  = !(mr[7:6] == 2'b11 && (kind == 3'd4 || kind == 3'd5 || kind == 3'd7));
      if (bad || c == 0) return;
      orig = m_reg[mr[2:0]];
      v = orig;
      lastbit = 1'b0;
      for (int k = 0; k < c; k++) begin
         if (kind == 3'd4) begin lastbit = v[31]; v = {v[30:0], 1'b0}; end
         else if (kind == 3'd5) begin lastbit = v[0]; v = {1'b0, v[31:1]}; end
         else begin lastbit = v[0]; v = {v[31], v[31:1]}; end
      end
      m_reg[mr[2:0]] = v;
      m_zf = (v == 32'd0);
      m_sf = (kind == 3'd5) ? 1'b0 : v[31];
      m_cf = lastbit;
      if (c == 1) begin
         if (kind == 3'd4)      m_of = orig[31] ^ orig[30];
         else if (kind == 3'd5) m_of = orig[31];
         else                   m_of = 1'b0;
      end
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic push_exp(input string tag, input logic [2:0] idx);
      exp_t e;
      e.tag = tag;
      e.idx = idx;
      e.val = m_reg[idx];
      e.flg = {m_zf, m_sf, m_of, m_cf};
      sb_q.push_back(e);
   endtask

   task automatic do_load(input logic [2:0] idx, input logic [31:0] val);
      @(negedge clk); #1;
      ld_en = 1'b1; ld_idx = idx; ld_data = val;
      @(posedge clk); #1;
      ld_en = 1'b0;
      m_reg[idx] = val;
   endtask

   task automatic do_exec(input string tag, input logic [7:0] mr, input logic [7:0] cb,
                          input bit collide, input logic [31:0] ld_val);
      logic bad;
      @(negedge clk); #1;
      valid = 1'b1; modrm = mr; count_byte = cb; rd_idx = mr[2:0];
      if (collide) begin ld_en = 1'b1; ld_idx = mr[2:0]; ld_data = ld_val; end
      model_exec(mr, cb, bad);
      #1;
      check_bit({tag, " err"}, err, bad);
      @(posedge clk); #1;
      valid = 1'b0; ld_en = 1'b0;
      push_exp(tag, mr[2:0]);
   endtask

   // Monitor: compare queued expectations away from the active edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_vec++;
         if (rd_idx != e.idx) rd_idx = e.idx;
         #0;
         if (rd_data !== e.val || {zf, sf, of, cf} !== e.flg) begin
            n_bad++;
            $display("FAIL %s: actual data %h flags %b expected data %h flags %b",
                     e.tag, rd_data, {zf, sf, of, cf}, e.val, e.flg);
         end
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) m_reg[i] = '0;
      {m_zf, m_sf, m_of, m_cf} = '0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // R11: every register and flag cleared
      for (int i = 0; i < 8; i++) push_exp("R11 reset state", 3'(i));
      @(negedge clk); #2;

      // R1 R3: base register, 13 << 1
      do_load(3'd3, 32'd13);
      do_exec("R3 shl 13 by 1 (R1)", 8'hE3, 8'd1, 0, '0);
      // R4: logical right of 26 and 27
      do_load(3'd3, 32'd26);
      do_exec("R4 shr 26", 8'hEB, 8'd1, 0, '0);
      do_load(3'd3, 32'd27);
      do_exec("R4 shr 27 (R7 cf)", 8'hEB, 8'd1, 0, '0);
      // R5: arithmetic right of 26 and 27
      do_load(3'd3, 32'd26);
      do_exec("R5 sar 26", 8'hFB, 8'd1, 0, '0);
      do_load(3'd3, 32'd27);
      do_exec("R5 sar 27", 8'hFB, 8'd1, 0, '0);
      // R5 R8: sign fill, overflow cleared
      do_load(3'd3, 32'hFFFF_FFFD);
      do_exec("R5 sar negative (R8 of=0)", 8'hFB, 8'd1, 0, '0);
      // R4 R6 R8: zero fill, sf cleared, of from bit 31
      do_load(3'd3, 32'hFFFF_FFFD);
      do_exec("R4 shr negative (R6 R8)", 8'hEB, 8'd1, 0, '0);
      // R8: left by one with bits 31:30 differing
      do_load(3'd1, 32'h4000_0000);
      do_exec("R8 shl of set (R6 sf)", 8'hE1, 8'd1, 0, '0);
      // R8: count above one keeps of
      do_load(3'd2, 32'h0000_00F0);
      do_exec("R8 of hold at count 4", 8'hEA, 8'd4, 0, '0);
      // R6 R7: left result zero with carry out
      do_load(3'd5, 32'h8000_0000);
      do_exec("R6 zero result (R7 cf)", 8'hE5, 8'd1, 0, '0);
      // R2: upper count bits ignored
      do_load(3'd4, 32'h0000_0C00);
      do_exec("R2 count 0x21 acts as 1", 8'hEC, 8'h21, 0, '0);
      // R9: masked zero count
      do_load(3'd6, 32'h1234_5678);
      do_exec("R9 count 0x20 no change", 8'hE6, 8'h20, 0, '0);
      do_exec("R9 count 0 no change", 8'hFE, 8'h00, 0, '0);
      // R7: maximum count
      do_load(3'd7, 32'hA000_0001);
      do_exec("R7 shl by 31", 8'hE7, 8'd31, 0, '0);
      do_load(3'd7, 32'hC000_0000);
      do_exec("R7 sar by 31", 8'hFF, 8'd31, 0, '0);
      // R10: undefined kind and non-register mode
      do_load(3'd3, 32'h0000_0055);
      do_exec("R10 kind 6 trapped", 8'hF3, 8'd1, 0, '0);
      do_exec("R10 kind 0 trapped", 8'hC3, 8'd2, 0, '0);
      do_exec("R10 memory mode trapped", 8'h63, 8'd1, 0, '0);
      // R12: shift wins over same-edge load
      do_load(3'd0, 32'h0000_0003);
      do_exec("R12 shift beats load", 8'hE0, 8'd2, 1, 32'hDEAD_BEEF);
      // R12: load and read on every register
      for (int i = 0; i < 8; i++) begin
         do_load(3'(i), 32'h0101_0101 * (i + 1));
         push_exp("R12 load readback", 3'(i));
         @(negedge clk); #2;
      end
      // R3 R4 R5 R7: random sweep
      for (int i = 0; i < 150; i++) begin
         logic [2:0]  r;
         logic [2:0]  kd;
         logic [7:0]  cb;
         int          pick;
         r    = 3'($urandom_range(0, 7));
         pick = $urandom_range(0, 2);
         kd   = (pick == 0) ? 3'd4 : (pick == 1) ? 3'd5 : 3'd7;
         cb   = 8'($urandom_range(0, 255));
         do_load(r, $urandom());
         do_exec("R7 random sweep", {2'b11, kd, r}, cb, 0, '0);
      end
      @(negedge clk); #2;
      @(negedge clk); #2;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule